// File: doc/BRIEF.md
# MII Receive Deframer with Preamble Suppression

This block sits between the nibble decoder of a twisted-pair receiver and a MAC. It takes a decoded nibble stream together with a carrier-present flag, a nibble-valid flag and a pass-through error flag. From these it launches the four MII receive signals on the falling edge of the receive clock: the data nibble, data valid, receive error and carrier sense. A mode input decides how much of the preamble reaches the controller. All preamble nibbles can be passed, a fixed number of leading nibbles can be dropped, or everything up to the delimiter nibble can be removed.

A second stage samples those MII signals on the rising edge, as a MAC does. It hunts for the `1101` delimiter nibble and pairs the following nibbles into bytes, low nibble first. It hands out each byte with start-of-frame and end-of-frame markers, a byte error flag, and an alignment error flag for frames that stop halfway through a byte. The assembler holds one complete byte back, so that the last byte of a frame can carry its end marker when valid drops.

Top module: `mii_rx_deframer`

## Requirements
- R1: The MII outputs (`mii_rxd`, `mii_rx_dv`, `mii_rx_er`, `mii_crs`) are registered on the falling edge of `rx_clk`. All outputs are zero during reset.
- R2: `mii_crs` is the value of `car_in` captured at the previous falling edge, whatever the state of `nib_valid`.
- R3: With `strip_mode` = 0 (pass all), every nibble presented with `nib_valid` high appears on `mii_rxd` with `mii_rx_dv` high at the next falling edge.
- R4: With `strip_mode` = 2 (strip all), valid nibbles before the first `1101` nibble are dropped, and `mii_rx_dv` first rises together with `mii_rxd` = `1101`. Mode 3 behaves the same as mode 2.
- R5: With `strip_mode` = 1 (strip some), the first `DROP_NIB` (default 4) valid nibbles before the delimiter are dropped, and the rest of the preamble is passed.
- R6: While `mii_rx_dv` is low, `mii_rxd` is 0 and `mii_rx_er` is 0. While it is high, `mii_rx_er` follows `nib_err`.
- R7: The byte assembler ignores every nibble received with `mii_rx_dv` high until it sees a `1101` nibble. A frame that has no delimiter yields no bytes.
- R8: After the delimiter, each pair of nibbles forms one byte with the first nibble in bits 3:0 and the second in bits 7:4.
- R9: The first byte of each frame has `byte_sof` set. `byte_sof` never appears without `byte_valid`.
- R10: When `mii_rx_dv` falls, the last complete byte of the frame is emitted with `byte_eof` set. No earlier byte carries `byte_eof`.
- R11: If an odd number of nibbles follows the delimiter, the final byte carries `byte_align_err` together with `byte_eof`.
- R12: `byte_err` is set on a byte when either of its two nibbles was received with `mii_rx_er` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock; MII launched on falling edge, bytes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strip_mode | input | 2 | 0 pass preamble, 1 drop first DROP_NIB nibbles, 2/3 drop all up to delimiter |
| car_in | input | 1 | Carrier present on the line |
| nib_valid | input | 1 | Decoded nibble is valid |
| nib_data | input | 4 | Decoded nibble, bit 0 first on the wire |
| nib_err | input | 1 | Decoder error for this nibble, passed through |
| mii_rxd | output | 4 | MII receive data |
| mii_rx_dv | output | 1 | MII receive data valid |
| mii_rx_er | output | 1 | MII receive error |
| mii_crs | output | 1 | MII carrier sense |
| byte_data | output | 8 | Assembled byte, zero when not valid |
| byte_valid | output | 1 | One-cycle strobe for an assembled byte |
| byte_sof | output | 1 | Byte is the first of its frame |
| byte_eof | output | 1 | Byte is the last of its frame |
| byte_align_err | output | 1 | Frame ended on an odd nibble |
| byte_err | output | 1 | A nibble of this byte carried an error |

## Verification
The assertions check, on every edge, several properties of the outputs. Carrier sense must track the carrier input one falling edge later. The data nibble and error must be quiet whenever data valid is low. In strip-all mode, valid must always rise on the delimiter nibble. The byte markers must keep their relations: start, end and alignment flags only ride on a valid byte, and an alignment error only comes with an end marker. Only the bench's scenarios can show the actual data behaviour. That covers which preamble nibbles each mode drops and the low-nibble-first byte values. It also covers discarding junk before the delimiter, the end marker landing on the last byte, and odd-length and errored frames.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  localparam logic [3:0] SFD_NIB = 4'b1101;

  typedef enum logic [1:0] {
    STRIP_NONE = 2'd0,
    STRIP_SOME = 2'd1,
    STRIP_ALL  = 2'd2,
    STRIP_ALT  = 2'd3
  } strip_mode_e;

  typedef enum logic [1:0] {
    ASM_HUNT = 2'd0,
    ASM_LO   = 2'd1,
    ASM_HI   = 2'd2
  } asm_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       sof;
    logic       err;
  } byte_rec_t;

  function automatic logic is_sfd(input logic [3:0] n);
    return n == SFD_NIB;
  endfunction

  // Decide whether a preamble nibble (before delimiter) passes.
  function automatic logic pre_pass(input logic [1:0] mode, input logic drop_done);
    case (mode)
      STRIP_NONE: return 1'b1;
      STRIP_SOME: return drop_done;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] join_nibbles(input logic [3:0] lo, input logic [3:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/mii_rx_pre_filter.sv
module mii_rx_pre_filter #(
  parameter int DROP_NIB = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_valid,
  input  logic [3:0] nib,
  input  logic [1:0] mode,
  output logic       pass_o,
  output logic       sfd_hit_o
);
  import mii_rx_pkg::*;

  localparam int CW = $clog2(DROP_NIB + 1) < 1 ? 1 : $clog2(DROP_NIB + 1);
  localparam logic [CW-1:0] DROP_LIM = CW'(DROP_NIB);

  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          drop_done;

  assign drop_done = cnt_q >= DROP_LIM;
  assign sfd_hit_o = nib_valid && !seen_q && is_sfd(nib);
  assign pass_o    = nib_valid && (seen_q || sfd_hit_o || pre_pass(mode, drop_done));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!nib_valid) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sfd_hit_o) begin
      seen_q <= 1'b1;
    end else if (!seen_q && !drop_done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the drop counter never runs past its limit
  p_cnt_bounded_r5: assert property (@(negedge clk) disable iff (!rst_n)
    cnt_q <= DROP_LIM);

endmodule

// File: rtl/mii_rx_launch.sv
module mii_rx_launch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pass,
  input  logic [3:0] nib,
  input  logic       err,
  input  logic       car,
  output logic [3:0] rxd_o,
  output logic       dv_o,
  output logic       er_o,
  output logic       crs_o
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_o <= '0;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
      crs_o <= 1'b0;
    end else begin
      rxd_o <= pass ? nib : 4'h0;
      dv_o  <= pass;
      er_o  <= pass && err;
      crs_o <= car;
    end
  end

endmodule

// File: rtl/mii_rx_byte_asm.sv
module mii_rx_byte_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dv,
  input  logic [3:0] rxd,
  input  logic       er,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_align,
  output logic       out_err
);
  import mii_rx_pkg::*;

  asm_state_e state_q;
  logic [3:0] lo_q;
  logic       lo_err_q;
  logic       first_q;
  logic       pend_valid_q;
  byte_rec_t  pend_q;

  // named events for assertions
  logic sfd_found;
  logic byte_done;
  logic frame_end;

  assign sfd_found = dv && (state_q == ASM_HUNT) && is_sfd(rxd);
  assign byte_done = dv && (state_q == ASM_HI);
  assign frame_end = !dv && (state_q != ASM_HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ASM_HUNT;
      lo_q         <= '0;
      lo_err_q     <= 1'b0;
      first_q      <= 1'b1;
      pend_valid_q <= 1'b0;
      pend_q       <= '0;
      out_data     <= '0;
      out_valid    <= 1'b0;
      out_sof      <= 1'b0;
      out_eof      <= 1'b0;
      out_align    <= 1'b0;
      out_err      <= 1'b0;
    end else begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_align <= 1'b0;
      out_err   <= 1'b0;
      if (sfd_found) begin
        state_q <= ASM_LO;
      end else if (dv && state_q == ASM_LO) begin
        lo_q     <= rxd;
        lo_err_q <= er;
        state_q  <= ASM_HI;
      end else if (byte_done) begin
        if (pend_valid_q) begin
          out_data  <= pend_q.data;
          out_valid <= 1'b1;
          out_sof   <= pend_q.sof;
          out_err   <= pend_q.err;
        end
        pend_q.data  <= join_nibbles(lo_q, rxd);
        pend_q.sof   <= first_q;
        pend_q.err   <= lo_err_q || er;
        pend_valid_q <= 1'b1;
        first_q      <= 1'b0;
        state_q      <= ASM_LO;
      end else if (frame_end) begin
        if (pend_valid_q) begin
          out_data  <= pend_q.data;
          out_valid <= 1'b1;
          out_sof   <= pend_q.sof;
          out_err   <= pend_q.err;
          out_eof   <= 1'b1;
          out_align <= (state_q == ASM_HI);
        end
        pend_valid_q <= 1'b0;
        first_q      <= 1'b1;
        state_q      <= ASM_HUNT;
      end
    end
  end

  // R11: alignment error only on the closing byte
  p_align_with_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_align |-> out_eof);
  // R10: end marker only on a valid byte
  p_eof_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);
  // R9: start marker only on a valid byte
  p_sof_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  // R7: no byte is produced while still hunting inside a frame
  p_hunt_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ASM_HUNT && dv) |=> !out_valid);

endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer #(
  parameter int DROP_NIB = 4
) (
  input  logic       rx_clk,
  input  logic       rst_n,
  input  logic [1:0] strip_mode,
  input  logic       car_in,
  input  logic       nib_valid,
  input  logic [3:0] nib_data,
  input  logic       nib_err,
  output logic [3:0] mii_rxd,
  output logic       mii_rx_dv,
  output logic       mii_rx_er,
  output logic       mii_crs,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       byte_sof,
  output logic       byte_eof,
  output logic       byte_align_err,
  output logic       byte_err
);
  import mii_rx_pkg::*;

  logic nib_pass;
  logic sfd_hit;

  mii_rx_pre_filter #(.DROP_NIB(DROP_NIB)) filt_i (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .nib_valid (nib_valid),
    .nib       (nib_data),
    .mode      (strip_mode),
    .pass_o    (nib_pass),
    .sfd_hit_o (sfd_hit)
  );

  mii_rx_launch launch_i (
    .clk   (rx_clk),
    .rst_n (rst_n),
    .pass  (nib_pass),
    .nib   (nib_data),
    .err   (nib_err),
    .car   (car_in),
    .rxd_o (mii_rxd),
    .dv_o  (mii_rx_dv),
    .er_o  (mii_rx_er),
    .crs_o (mii_crs)
  );

  mii_rx_byte_asm asm_i (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .dv        (mii_rx_dv),
    .rxd       (mii_rxd),
    .er        (mii_rx_er),
    .out_data  (byte_data),
    .out_valid (byte_valid),
    .out_sof   (byte_sof),
    .out_eof   (byte_eof),
    .out_align (byte_align_err),
    .out_err   (byte_err)
  );

  // R6: quiet data and error while not valid
  p_rxd_zero_idle_r6: assert property (@(negedge rx_clk) disable iff (!rst_n)
    !mii_rx_dv |-> (mii_rxd == 4'h0));
  p_er_needs_dv_r6: assert property (@(negedge rx_clk) disable iff (!rst_n)
    mii_rx_er |-> mii_rx_dv);
  // R2: carrier sense is the carrier input one falling edge later
  p_crs_follow_r2: assert property (@(negedge rx_clk) disable iff (!rst_n)
    $past(rst_n) |-> (mii_crs == $past(car_in)));
  // R4: in strip-all mode, valid rises on the delimiter
  p_full_strip_first_r4: assert property (@(negedge rx_clk) disable iff (!rst_n)
    (strip_mode[1] && $rose(mii_rx_dv)) |-> (mii_rxd == SFD_NIB));
  // R4: the filter only marks a delimiter on a valid nibble
  p_sfd_hit_valid_r4: assert property (@(negedge rx_clk) disable iff (!rst_n)
    sfd_hit |-> nib_pass);

endmodule

// File: tb/mii_rx_deframer_tb.sv
module mii_rx_deframer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       car = 1'b0, nv = 1'b0, ne = 1'b0;
  logic [3:0] nd = 4'h0;
  logic [3:0] mii_rxd;
  logic       mii_dv, mii_er, mii_crs;
  logic [7:0] b_data;
  logic       b_valid, b_sof, b_eof, b_align, b_err;

  int checks = 0;
  int failures = 0;

  logic [3:0] s_rxd;
  logic       s_dv, s_er, s_crs;

  logic [7:0] bq_data  [0:31];
  logic       bq_sof   [0:31];
  logic       bq_eof   [0:31];
  logic       bq_align [0:31];
  logic       bq_err   [0:31];
  int         bcnt = 0;

  always #4 clk = ~clk;

  mii_rx_deframer dut_i (
    .rx_clk(clk), .rst_n(rst_n), .strip_mode(mode), .car_in(car),
    .nib_valid(nv), .nib_data(nd), .nib_err(ne),
    .mii_rxd(mii_rxd), .mii_rx_dv(mii_dv), .mii_rx_er(mii_er), .mii_crs(mii_crs),
    .byte_data(b_data), .byte_valid(b_valid), .byte_sof(b_sof),
    .byte_eof(b_eof), .byte_align_err(b_align), .byte_err(b_err)
  );

  always @(negedge clk) begin
    if (b_valid && bcnt < 32) begin
      bq_data[bcnt]  = b_data;
      bq_sof[bcnt]   = b_sof;
      bq_eof[bcnt]   = b_eof;
      bq_align[bcnt] = b_align;
      bq_err[bcnt]   = b_err;
      bcnt = bcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one nibble period, sample MII after the falling edge
  task automatic step(input logic v, input logic [3:0] n, input logic c, input logic e);
    @(posedge clk); #1;
    nv = v; nd = n; car = c; ne = e;
    @(negedge clk); #1;
    s_rxd = mii_rxd; s_dv = mii_dv; s_er = mii_er; s_crs = mii_crs;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk(mii_rxd == 0 && !mii_dv && !mii_er && !mii_crs, "R1 reset mii", {mii_rxd, mii_dv, mii_er, mii_crs}, 0);
    chk(!b_valid && b_data == 0 && !b_sof && !b_eof, "R1 reset byte", {b_data, b_valid}, 0);
  endtask

  task automatic t_pass_all;
    bcnt = 0; mode = 2'd0;
    step(1'b0, 4'h0, 1'b1, 1'b0);
    chk(s_crs && !s_dv, "R2 crs before data", {s_crs, s_dv}, 2);
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 4'h5, 1'b1, 1'b0);
      if (i == 0) chk(s_dv && s_rxd == 4'h5, "R3 first preamble passed", {s_dv, s_rxd}, 5'h15);
    end
    step(1'b1, 4'hD, 1'b1, 1'b0);
    chk(s_dv && s_rxd == 4'hD, "R3 delimiter passed", s_rxd, 4'hD);
    step(1'b1, 4'h3, 1'b1, 1'b0);
    step(1'b1, 4'hA, 1'b1, 1'b0);
    step(1'b1, 4'hC, 1'b1, 1'b0);
    step(1'b1, 4'h1, 1'b1, 1'b0);
    step(1'b0, 4'h0, 1'b0, 1'b0);
    chk(!s_crs, "R2 crs drops", s_crs, 0);
    idle(4);
    chk(bcnt == 2, "R8 byte count", bcnt, 2);
    chk(bq_data[0] == {4'hA, 4'h3} && bq_sof[0] && !bq_eof[0], "R8 R9 first byte", {bq_sof[0], bq_eof[0], bq_data[0]}, 10'h2A3);
    chk(bq_data[1] == {4'h1, 4'hC} && !bq_sof[1] && bq_eof[1] && !bq_align[1], "R10 last byte eof", {bq_sof[1], bq_eof[1], bq_data[1]}, 10'h11C);
  endtask

  task automatic t_strip_all(input logic [1:0] m);
    bcnt = 0; mode = m;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 4'h5, 1'b1, 1'b0);
      chk(!s_dv && s_rxd == 0, "R4 preamble dropped", {s_dv, s_rxd}, 0);
    end
    step(1'b1, 4'hD, 1'b1, 1'b0);
    chk(s_dv && s_rxd == 4'hD, "R4 dv rises on delimiter", {s_dv, s_rxd}, 5'h1D);
    step(1'b1, 4'h2, 1'b1, 1'b0);
    step(1'b1, 4'h7, 1'b1, 1'b0);
    idle(4);
    chk(bcnt == 1 && bq_data[0] == 8'h72 && bq_sof[0] && bq_eof[0], "R4 R8 strip-all byte", {bcnt[3:0], bq_data[0]}, 12'h172);
  endtask

  task automatic t_strip_some;
    bcnt = 0; mode = 2'd1;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 4'h5, 1'b1, 1'b0);
      if (i < 4) chk(!s_dv, "R5 leading nibble dropped", s_dv, 0);
      else       chk(s_dv && s_rxd == 4'h5, "R5 later nibble passed", {s_dv, s_rxd}, 5'h15);
    end
    step(1'b1, 4'hD, 1'b1, 1'b0);
    step(1'b1, 4'h1, 1'b1, 1'b0);
    step(1'b1, 4'h2, 1'b1, 1'b0);
    idle(4);
    chk(bcnt == 1 && bq_data[0] == 8'h21, "R5 R8 byte after partial strip", bq_data[0], 8'h21);
  endtask

  task automatic t_odd;
    bcnt = 0; mode = 2'd0;
    step(1'b1, 4'h5, 1'b1, 1'b0);
    step(1'b1, 4'h5, 1'b1, 1'b0);
    step(1'b1, 4'hD, 1'b1, 1'b0);
    step(1'b1, 4'h3, 1'b1, 1'b0);
    step(1'b1, 4'hA, 1'b1, 1'b0);
    step(1'b1, 4'hC, 1'b1, 1'b0);
    idle(4);
    chk(bcnt == 1, "R11 odd frame byte count", bcnt, 1);
    chk(bq_data[0] == 8'hA3 && bq_eof[0] && bq_align[0], "R11 align error with eof", {bq_eof[0], bq_align[0], bq_data[0]}, 10'h3A3);
  endtask

  task automatic t_junk;
    bcnt = 0; mode = 2'd0;
    step(1'b1, 4'h5, 1'b1, 1'b0);
    step(1'b1, 4'h7, 1'b1, 1'b0);
    step(1'b1, 4'h2, 1'b1, 1'b0);
    step(1'b1, 4'h5, 1'b1, 1'b0);
    step(1'b1, 4'hD, 1'b1, 1'b0);
    step(1'b1, 4'h4, 1'b1, 1'b0);
    step(1'b1, 4'hB, 1'b1, 1'b0);
    idle(4);
    chk(bcnt == 1 && bq_data[0] == 8'hB4 && bq_sof[0], "R7 junk before delimiter ignored", {bcnt[3:0], bq_data[0]}, 12'h1B4);
  endtask

  task automatic t_error;
    bcnt = 0; mode = 2'd0;
    step(1'b0, 4'h9, 1'b1, 1'b1);
    chk(!s_er && s_rxd == 0, "R6 error ignored without valid", {s_er, s_rxd}, 0);
    step(1'b1, 4'h5, 1'b1, 1'b0);
    step(1'b1, 4'hD, 1'b1, 1'b0);
    step(1'b1, 4'h6, 1'b1, 1'b1);
    chk(s_er && s_dv, "R6 error passed with data", {s_er, s_dv}, 3);
    step(1'b1, 4'h9, 1'b1, 1'b0);
    chk(!s_er, "R6 error clears", s_er, 0);
    step(1'b1, 4'h8, 1'b1, 1'b0);
    step(1'b1, 4'h8, 1'b1, 1'b0);
    idle(4);
    chk(bcnt == 2 && bq_data[0] == 8'h96 && bq_err[0], "R12 byte error flagged", {bq_err[0], bq_data[0]}, 9'h196);
    chk(!bq_err[1] && bq_data[1] == 8'h88, "R12 clean byte", {bq_err[1], bq_data[1]}, 9'h088);
  endtask

  task automatic t_no_sfd;
    bcnt = 0; mode = 2'd2;
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 4'h5, 1'b1, 1'b0);
      chk(!s_dv, "R4 no delimiter keeps dv low", s_dv, 0);
    end
    idle(4);
    chk(bcnt == 0, "R7 no bytes without delimiter", bcnt, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_pass_all();
    t_strip_all(2'd2);
    t_strip_all(2'd3);
    t_strip_some();
    t_odd();
    t_junk();
    t_error();
    t_no_sfd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule